// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small pool of recent page translations for a processor's memory management path. A lookup strobe presents a virtual address. The page number taken from its upper bits is compared against every stored entry in the same cycle. One clock later the block reports a hit, with the physical frame number, protection code and modify bit of the matching entry, or it reports a miss. Entries for system space and process space share a single pool, and no entry is reserved for either space.

On a miss the block does nothing further. An outside agent resolves the translation and writes it back through the fill port. The fill goes to the lowest-numbered empty entry. When no entry is empty it replaces the entry that has gone longest without use, under an exact recency order over all entries. Three invalidate inputs remove stale entries: one page at a time, all process-space pages, or everything.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, and lk_valid_o, lk_hit_o and lk_miss_o are low.
- R2: lk_valid_o is high in exactly the cycle after a cycle with lk_req_i high, and low otherwise.
- R3: The page number is address bits [31:9]. A lookup that matches a valid entry gives lk_hit_o=1 and lk_miss_o=0 one clock later, with lk_pfn_o, lk_prot_o and lk_mod_o taken from that entry.
- R4: A lookup that matches no valid entry gives lk_miss_o=1 and lk_hit_o=0 one clock later. Whenever there is no hit, lk_pfn_o, lk_prot_o and lk_mod_o read zero.
- R5: A fill for a page not present goes to the lowest-indexed invalid entry. Eight fills of distinct pages into an empty cache leave all eight pages resident.
- R6: When every entry is valid, a fill for a new page evicts the least recently used entry. A hit or a fill makes an entry most recently used. All other pages stay resident.
- R7: A fill whose page already sits in a valid entry rewrites that entry in place and marks it most recently used. No page ever occupies two entries.
- R8: A lookup and a fill in the same cycle both take effect. The lookup reports the contents as they were before the fill, and a fill of the looked-up page creates no duplicate.
- R9: inv_one_i clears only the valid entry whose page matches inv_va_i[31:9].
- R10: flush_proc_i clears every entry whose address bit 31 is 0. Entries with bit 31 set stay resident.
- R11: flush_all_i clears every entry.
- R12: In a cycle where any invalidate input is high, a fill has no effect and a lookup hit does not change the recency order. The lookup result is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup strobe |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss, refill needed |
| lk_pfn_o | output | 21 | Physical frame number on hit |
| lk_prot_o | output | 4 | Protection code on hit |
| lk_mod_o | output | 1 | Modify bit on hit |
| fill_i | input | 1 | Fill strobe |
| fill_va_i | input | 32 | Fill virtual address |
| fill_pfn_i | input | 21 | Fill frame number |
| fill_prot_i | input | 4 | Fill protection code |
| fill_mod_i | input | 1 | Fill modify bit |
| inv_one_i | input | 1 | Invalidate the single page of inv_va_i |
| inv_va_i | input | 32 | Address to invalidate |
| flush_proc_i | input | 1 | Invalidate all process-space entries |
| flush_all_i | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default parameters: eight entries, 32-bit addresses, 512-byte pages, a 21-bit frame number and a 4-bit protection field. A full pool of eight therefore fills after a handful of refills. The random phase draws from only twelve pages split across both address spaces, so evictions, same-page fill and lookup collisions, and process-only flushes over mixed contents all occur often. The recency order is compared entry by entry against a queue model.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_INVAL = 2'd1,
    OP_FILL  = 2'd2,
    OP_HIT   = 2'd3
  } xc_op_e;
endpackage

// File: rtl/xc_cam.sv
module xc_cam #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 23
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]              probe_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (keys_i[g] == probe_i);
  end
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            touch_i,
  input  logic [IDX_W-1:0]                touch_idx_i,
  output logic [ENTRIES-1:0][IDX_W-1:0]   rank_o,
  output logic [IDX_W-1:0]                lru_idx_o
);
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
  logic [IDX_W-1:0]              old_rank;

  assign old_rank = rank_q[touch_idx_i];
  assign rank_o   = rank_q;

  // rank 0 = most recent, ENTRIES-1 = victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)   rank_q[i] <= '0;
        else if (rank_q[i] < old_rank)  rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rank_q[i] == IDX_W'(ENTRIES - 1)) lru_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   lru_idx_i,
  output logic [IDX_W-1:0]   victim_o
);
  always_comb begin
    victim_o = lru_idx_i;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) victim_o = IDX_W'(i);
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 9,
  parameter int PFN_W     = 21,
  parameter int PROT_W    = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_valid_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic [PROT_W-1:0] lk_prot_o,
  output logic              lk_mod_o,
  input  logic              fill_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [PROT_W-1:0] fill_prot_i,
  input  logic              fill_mod_i,
  input  logic              inv_one_i,
  input  logic [VA_W-1:0]   inv_va_i,
  input  logic              flush_proc_i,
  input  logic              flush_all_i
);
  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0]   ent_pfn;
  logic [ENTRIES-1:0][PROT_W-1:0]  ent_prot;
  logic [ENTRIES-1:0]              ent_mod;
  logic [ENTRIES-1:0][IDX_W-1:0]   rank;

  logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
  logic [IDX_W-1:0]   lk_idx, fill_hit_idx, victim_idx, lru_idx, fill_idx, touch_idx;
  logic               lk_any, fill_any, touch;
  xc_op_e             op;

  xc_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_lk (
    .valid_i(ent_valid), .keys_i(ent_vpn),
    .probe_i(lk_va_i[VA_W-1:PAGE_BITS]), .match_o(lk_match));
  xc_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_fill (
    .valid_i(ent_valid), .keys_i(ent_vpn),
    .probe_i(fill_va_i[VA_W-1:PAGE_BITS]), .match_o(fill_match));
  xc_cam #(.ENTRIES(ENTRIES), .KEY_W(VPN_W)) u_cam_inv (
    .valid_i(ent_valid), .keys_i(ent_vpn),
    .probe_i(inv_va_i[VA_W-1:PAGE_BITS]), .match_o(inv_match));

  always_comb begin
    lk_idx       = '0;
    fill_hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i])   lk_idx       = IDX_W'(i);
      if (fill_match[i]) fill_hit_idx = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_match;
  assign fill_any = |fill_match;

  xc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i(ent_valid), .lru_idx_i(lru_idx), .victim_o(victim_idx));

  // invalidates win over fill, fill wins over the hit touch
  always_comb begin
    if (flush_all_i || flush_proc_i || inv_one_i) op = OP_INVAL;
    else if (fill_i)                              op = OP_FILL;
    else if (lk_req_i && lk_any)                  op = OP_HIT;
    else                                          op = OP_IDLE;
  end

  assign fill_idx  = fill_any ? fill_hit_idx : victim_idx;
  assign touch     = (op == OP_FILL) || (op == OP_HIT);
  assign touch_idx = (op == OP_FILL) ? fill_idx : lk_idx;

  xc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(touch_idx), .rank_o(rank), .lru_idx_o(lru_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid <= '0;
    end else if (op == OP_INVAL) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all_i
            || (flush_proc_i && !ent_vpn[i][VPN_W-1])
            || (inv_one_i && inv_match[i]))
          ent_valid[i] <= 1'b0;
      end
    end else if (op == OP_FILL) begin
      ent_valid[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (op == OP_FILL) begin
      ent_vpn[fill_idx]  <= fill_va_i[VA_W-1:PAGE_BITS];
      ent_pfn[fill_idx]  <= fill_pfn_i;
      ent_prot[fill_idx] <= fill_prot_i;
      ent_mod[fill_idx]  <= fill_mod_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_miss_o  <= 1'b0;
      lk_pfn_o   <= '0;
      lk_prot_o  <= '0;
      lk_mod_o   <= 1'b0;
    end else begin
      lk_valid_o <= lk_req_i;
      lk_hit_o   <= lk_req_i && lk_any;
      lk_miss_o  <= lk_req_i && !lk_any;
      lk_pfn_o   <= (lk_req_i && lk_any) ? ent_pfn[lk_idx]  : '0;
      lk_prot_o  <= (lk_req_i && lk_any) ? ent_prot[lk_idx] : '0;
      lk_mod_o   <= lk_req_i && lk_any && ent_mod[lk_idx];
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          lk_req_i,
  input logic                          lk_valid_o,
  input logic                          lk_hit_o,
  input logic                          lk_miss_o,
  input logic                          flush_all_i,
  input logic [ENTRIES-1:0]            valid_vec,
  input logic [ENTRIES-1:0]            lk_match,
  input logic [ENTRIES-1:0][IDX_W-1:0] rank_vec
);
  logic [ENTRIES-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < ENTRIES; i++) rank_seen[rank_vec[i]] = 1'b1;
  end

  a_r2_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o);
  a_r2_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_valid_o);
  a_r3_match_gives_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && (|lk_match)) |=> lk_hit_o);
  a_r4_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_o |-> (lk_hit_o ^ lk_miss_o));
  a_r4_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_o |-> (!lk_hit_o && !lk_miss_o));
  a_r6_rank_permutation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &rank_seen);
  a_r7_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_vec == '0));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_valid_o(lk_valid_o),
  .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .flush_all_i(flush_all_i),
  .valid_vec(ent_valid), .lk_match(lk_match), .rank_vec(rank));

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_ni = 0;
  logic lk_req = 0, fill = 0, inv_one = 0, flush_proc = 0, flush_all = 0;
  logic [31:0] lk_va = 0, fill_va = 0, inv_va = 0;
  logic [20:0] fill_pfn = 0;
  logic [3:0]  fill_prot = 0;
  logic        fill_mod = 0;
  logic lk_valid, lk_hit, lk_miss, lk_mod;
  logic [20:0] lk_pfn;
  logic [3:0]  lk_prot;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cache uut (
    .clk_i(clk), .rst_ni(rst_ni), .lk_req_i(lk_req), .lk_va_i(lk_va),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_miss_o(lk_miss),
    .lk_pfn_o(lk_pfn), .lk_prot_o(lk_prot), .lk_mod_o(lk_mod),
    .fill_i(fill), .fill_va_i(fill_va), .fill_pfn_i(fill_pfn),
    .fill_prot_i(fill_prot), .fill_mod_i(fill_mod), .inv_one_i(inv_one),
    .inv_va_i(inv_va), .flush_proc_i(flush_proc), .flush_all_i(flush_all));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1";

  // reference: contents per slot plus a recency queue (front = newest)
  bit          m_v[N];
  logic [22:0] m_vpn[N];
  logic [20:0] m_pfn[N];
  logic [3:0]  m_prot[N];
  bit          m_mod[N];
  int          order[$];

  function automatic logic [31:0] mkva(bit sys, int pg);
    return {sys, 22'(pg), 9'($urandom_range(0, 511))};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void touch(int idx);
    foreach (order[k]) if (order[k] == idx) begin order.delete(k); break; end
    order.push_front(idx);
  endfunction

  function automatic int find(logic [22:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one clock: predict, advance, compare
  task automatic cyc();
    bit e_v, e_h, e_m, e_mod;
    logic [20:0] e_pfn;
    logic [3:0] e_prot;
    int li, fi, vi;
    li = find(lk_va[31:9]);
    e_v = lk_req; e_h = lk_req && li >= 0; e_m = lk_req && li < 0;
    e_pfn = e_h ? m_pfn[li] : 0; e_prot = e_h ? m_prot[li] : 0;
    e_mod = e_h ? m_mod[li] : 0;
    if (flush_all || flush_proc || inv_one) begin
      for (int i = 0; i < N; i++)
        if (flush_all || (flush_proc && !m_vpn[i][22])
            || (inv_one && m_vpn[i] == inv_va[31:9])) m_v[i] = 0;
    end else if (fill) begin
      fi = find(fill_va[31:9]);
      if (fi < 0) begin
        vi = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vi = i;
        fi = (vi >= 0) ? vi : order[$];
      end
      m_v[fi] = 1; m_vpn[fi] = fill_va[31:9]; m_pfn[fi] = fill_pfn;
      m_prot[fi] = fill_prot; m_mod[fi] = fill_mod;
      touch(fi);
    end else if (e_h) touch(li);
    @(posedge clk); @(negedge clk);
    chk(phase, "valid", lk_valid, e_v);
    chk(phase, "hit", lk_hit, e_h);
    chk(phase, "miss", lk_miss, e_m);
    chk(phase, "pfn", lk_pfn, e_pfn);
    chk(phase, "prot", lk_prot, e_prot);
    chk(phase, "mod", lk_mod, e_mod);
    lk_req = 0; fill = 0; inv_one = 0; flush_proc = 0; flush_all = 0;
  endtask

  task automatic look(logic [31:0] va);
    lk_req = 1; lk_va = va; cyc();
  endtask

  task automatic put(logic [31:0] va, logic [20:0] pfn);
    fill = 1; fill_va = va; fill_pfn = pfn;
    fill_prot = 4'($urandom); fill_mod = 1'($urandom); cyc();
  endtask

  logic [31:0] pg[12];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; order.push_back(i); end
    for (int i = 0; i < 12; i++) pg[i] = mkva(i % 3 == 0, 100 + i);
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", lk_valid, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", "hit after reset", lk_hit, 0);
    phase = "R1"; look(pg[0]);
    chk("R4", "miss empty", lk_miss, 1);
    phase = "R2"; cyc();

    phase = "R5";
    for (int i = 0; i < N; i++) put(pg[i], 21'(1000 + i));
    for (int i = 0; i < N; i++) begin
      phase = "R3"; look(pg[i]);
      chk("R5", "resident", lk_hit, 1);
      chk("R3", "frame", lk_pfn, 1000 + i);
    end

    phase = "R6";
    look(pg[0]); look(pg[1]);
    put(pg[8], 21'd2008);          // evicts pg[2]: oldest touch
    look(pg[2]);
    chk("R6", "lru evicted", lk_miss, 1);
    look(pg[3]);
    chk("R6", "others kept", lk_hit, 1);

    phase = "R7";
    put(pg[4], 21'h1abcd);
    look(pg[4]);
    chk("R7", "rewrite", lk_pfn, 21'h1abcd);

    phase = "R8";
    lk_req = 1; lk_va = pg[9]; fill = 1; fill_va = pg[9]; fill_pfn = 21'd77;
    cyc();
    chk("R8", "pre-fill miss", lk_miss, 1);
    lk_req = 1; lk_va = pg[9]; fill = 1; fill_va = pg[9]; fill_pfn = 21'd78;
    cyc();
    chk("R8", "pre-fill value", lk_pfn, 77);
    look(pg[9]);
    chk("R8", "fill landed", lk_pfn, 78);

    phase = "R9";
    inv_one = 1; inv_va = pg[9]; cyc();
    look(pg[9]);
    chk("R9", "cleared", lk_miss, 1);
    look(pg[3]);
    chk("R9", "neighbour kept", lk_hit, 1);

    phase = "R12";
    fill = 1; fill_va = pg[10]; fill_pfn = 21'd5; inv_one = 1; inv_va = pg[11];
    cyc();
    look(pg[10]);
    chk("R12", "fill ignored", lk_miss, 1);

    phase = "R10";
    flush_proc = 1; cyc();
    look(pg[0]);                   // bit 31 set
    chk("R10", "system kept", lk_hit, 1);
    look(pg[1]);                   // bit 31 clear
    chk("R10", "process gone", lk_miss, 1);

    phase = "R11";
    flush_all = 1; cyc();
    look(pg[0]);
    chk("R11", "all gone", lk_miss, 1);

    phase = "R6";
    for (int t = 0; t < 3000; t++) begin
      lk_req = 1'($urandom); lk_va = pg[$urandom_range(0, 11)];
      fill = ($urandom_range(0, 2) == 0); fill_va = pg[$urandom_range(0, 11)];
      fill_pfn = 21'($urandom); fill_prot = 4'($urandom); fill_mod = 1'($urandom);
      inv_one = ($urandom_range(0, 30) == 0); inv_va = pg[$urandom_range(0, 11)];
      flush_proc = ($urandom_range(0, 80) == 0);
      flush_all = ($urandom_range(0, 200) == 0);
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule